// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether the condition of a transfer-control instruction holds. It receives the instruction's condition controls (carry-test select, branch polarity, data-compare enable, phase-compare enable, wait-for-fresh-phase), the expected bus phase, an 8-bit compare value with its mask, and the live status: ALU carry, latched 3-bit bus phase, a pulse marking a newly latched unserviced phase, the first received data byte, the target/initiator mode and the attention line.

A `start` pulse issues an instruction. Without the wait option the condition is evaluated on the inputs present in the start cycle. With the wait option the block holds `busy` high until a fresh phase arrives, then evaluates on the inputs of that cycle. In both cases a registered `cond_met` is presented together with a one-cycle `result_valid` pulse. Latching of bus signals and the actual change of program flow are done elsewhere.

Top module: `branch_cond_eval`

## Requirements
- R1: When `cfg_carry_test` is 1, `cond_met` equals 1 exactly when `alu_carry` equals `cfg_polarity`; the phase and data compare enables and the attention line have no effect.
- R2: When `cfg_carry_test`, `cfg_data_en` and `cfg_phase_en` are all 0, `cond_met` is 1 for either polarity.
- R3: The data compare matches when every bit position with mask bit 0 has `first_byte` equal to `cfg_value`; a mask bit of 1 makes that position a don't-care.
- R4: In initiator mode (`target_mode`=0) the phase compare matches when `bus_phase` equals `cfg_phase`.
- R5: In target mode (`target_mode`=1) the phase compare matches when `atn_active` is 1, whatever `bus_phase` and `cfg_phase` are.
- R6: With polarity 1 the condition is met when every enabled compare matches; with polarity 0 it is met when every enabled compare mismatches.
- R7: With `cfg_wait_fresh`=0, `result_valid` is high for one cycle exactly one cycle after `start`, and `cond_met` reflects the inputs of the start cycle.
- R8: With `cfg_wait_fresh`=1, `busy` is high from the cycle after `start` until the first cycle in which `phase_fresh` is 1 (a `phase_fresh` in the start cycle itself does not count); that cycle's status inputs are evaluated against the configuration captured at `start`, and one cycle later `result_valid` pulses and `busy` is low.
- R9: A `start` while `busy` is high is ignored: it produces no result and does not replace the captured configuration.
- R10: After reset `busy`, `result_valid` and `cond_met` are 0; `cond_met` changes only in a cycle where `result_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue pulse for one instruction |
| cfg_carry_test | input | 1 | Test ALU carry only |
| cfg_polarity | input | 1 | 1: met when compares true; 0: met when false |
| cfg_data_en | input | 1 | Enable masked data compare |
| cfg_phase_en | input | 1 | Enable phase compare (attention test in target mode) |
| cfg_wait_fresh | input | 1 | Wait for a fresh unserviced phase before evaluating |
| cfg_phase | input | PHASE_W | Expected bus phase |
| cfg_mask | input | DATA_W | Per-bit don't-care mask |
| cfg_value | input | DATA_W | Expected data value |
| alu_carry | input | 1 | ALU carry flag |
| bus_phase | input | PHASE_W | Latched bus phase |
| phase_fresh | input | 1 | A new unserviced phase was latched this cycle |
| first_byte | input | DATA_W | First received data byte |
| target_mode | input | 1 | 1 target, 0 initiator |
| atn_active | input | 1 | Attention line asserted |
| busy | output | 1 | Waiting for a fresh phase |
| result_valid | output | 1 | One-cycle pulse: `cond_met` is new |
| cond_met | output | 1 | Registered condition result |

## Verification
The bench mixes seeded random configurations, biased so that data and phase compares often match, with directed corners: carry mode with both compares enabled and deliberately matching, so a design that leaked the compares into the carry test would give the wrong answer; no enables with polarity 0, where a design that still applied polarity would report unmet; a single unmasked bit differing, which catches a mask applied with inverted sense; and target mode with a matching phase but no attention, which catches a design that still compared phases. For the wait option it scrambles the configuration after issue, raises `phase_fresh` in the issue cycle and issues a second start while busy. A design that used live configuration, accepted the early phase or restarted would show a wrong result or wrong `busy` timing.

// File: rtl/bce_pkg.sv
package bce_pkg;
  typedef struct packed {
    logic carry_test;
    logic polarity;
    logic data_en;
    logic phase_en;
  } bce_flags_t;
endpackage

// File: rtl/bce_match.sv
module bce_match #(
  parameter int DATA_W  = 8,
  parameter int PHASE_W = 3
) (
  input  logic [DATA_W-1:0]  data_byte,
  input  logic [DATA_W-1:0]  exp_value,
  input  logic [DATA_W-1:0]  dc_mask,
  input  logic [PHASE_W-1:0] live_phase,
  input  logic [PHASE_W-1:0] exp_phase,
  input  logic               tgt_mode,
  input  logic               atn,
  output logic               data_hit,
  output logic               phase_hit
);
  logic [DATA_W-1:0] bit_ok;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign bit_ok[i] = dc_mask[i] | ~(data_byte[i] ^ exp_value[i]);
  end

  assign data_hit  = &bit_ok;
  assign phase_hit = tgt_mode ? atn : (live_phase == exp_phase);

  // R5: in target mode the phase result follows attention only
  always_comb begin
    if (tgt_mode) a_r5_target_atn: assert (phase_hit == atn);
  end
endmodule

// File: rtl/bce_decide.sv
module bce_decide
  import bce_pkg::*;
(
  input  bce_flags_t fl,
  input  logic       carry,
  input  logic       data_hit,
  input  logic       phase_hit,
  output logic       met
);
  logic d_ok, p_ok;

  always_comb begin
    d_ok = !fl.data_en  || (data_hit  == fl.polarity);
    p_ok = !fl.phase_en || (phase_hit == fl.polarity);
    if (fl.carry_test)                   met = (carry == fl.polarity);
    else if (!fl.data_en && !fl.phase_en) met = 1'b1;
    else                                 met = d_ok && p_ok;
  end

  // R2: nothing enabled means unconditionally met
  always_comb begin
    if (!fl.carry_test && !fl.data_en && !fl.phase_en)
      a_r2_uncond: assert (met);
  end
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import bce_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               cfg_carry_test,
  input  logic               cfg_polarity,
  input  logic               cfg_data_en,
  input  logic               cfg_phase_en,
  input  logic               cfg_wait_fresh,
  input  logic [PHASE_W-1:0] cfg_phase,
  input  logic [DATA_W-1:0]  cfg_mask,
  input  logic [DATA_W-1:0]  cfg_value,
  input  logic               alu_carry,
  input  logic [PHASE_W-1:0] bus_phase,
  input  logic               phase_fresh,
  input  logic [DATA_W-1:0]  first_byte,
  input  logic               target_mode,
  input  logic               atn_active,
  output logic               busy,
  output logic               result_valid,
  output logic               cond_met
);
  bce_flags_t         fl_in, fl_q, fl_ev;
  logic [PHASE_W-1:0] ph_q, ph_ev;
  logic [DATA_W-1:0]  mask_q, val_q, mask_ev, val_ev;
  logic               busy_q, valid_q, met_q;
  logic               accept, fire, data_hit, phase_hit, met_c;

  assign fl_in  = '{carry_test: cfg_carry_test, polarity: cfg_polarity,
                    data_en: cfg_data_en, phase_en: cfg_phase_en};
  assign accept = start && !busy_q;
  assign fire   = (accept && !cfg_wait_fresh) || (busy_q && phase_fresh);

  // configuration used for evaluation: live at issue, captured while waiting
  assign fl_ev   = busy_q ? fl_q   : fl_in;
  assign ph_ev   = busy_q ? ph_q   : cfg_phase;
  assign mask_ev = busy_q ? mask_q : cfg_mask;
  assign val_ev  = busy_q ? val_q  : cfg_value;

  bce_match #(.DATA_W(DATA_W), .PHASE_W(PHASE_W)) u_match (
    .data_byte (first_byte),
    .exp_value (val_ev),
    .dc_mask   (mask_ev),
    .live_phase(bus_phase),
    .exp_phase (ph_ev),
    .tgt_mode  (target_mode),
    .atn       (atn_active),
    .data_hit  (data_hit),
    .phase_hit (phase_hit)
  );

  bce_decide u_decide (
    .fl       (fl_ev),
    .carry    (alu_carry),
    .data_hit (data_hit),
    .phase_hit(phase_hit),
    .met      (met_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      met_q   <= 1'b0;
      fl_q    <= '0;
      ph_q    <= '0;
      mask_q  <= '0;
      val_q   <= '0;
    end else begin
      valid_q <= fire;
      if (fire) met_q <= met_c;
      if (accept) begin
        fl_q   <= fl_in;
        ph_q   <= cfg_phase;
        mask_q <= cfg_mask;
        val_q  <= cfg_value;
      end
      if (accept && cfg_wait_fresh)    busy_q <= 1'b1;
      else if (busy_q && phase_fresh)  busy_q <= 1'b0;
    end
  end

  assign busy         = busy_q;
  assign result_valid = valid_q;
  assign cond_met     = met_q;

  // R7: immediate evaluation answers one cycle after issue
  a_r7_imm_valid: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !cfg_wait_fresh) |=> (result_valid && !busy));

  // R8: waiting issue raises busy, no result yet
  a_r8_wait_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && cfg_wait_fresh) |=> (busy && !result_valid));

  // R8: fresh phase ends the wait with a result
  a_r8_wait_done: assert property (@(posedge clk) disable iff (rst)
    (busy && phase_fresh) |=> (result_valid && !busy));

  // R9: no fresh phase keeps waiting, any start is ignored
  a_r9_hold_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && !phase_fresh) |=> (busy && !result_valid));

  // R10: result only moves with the valid pulse
  a_r10_stable: assert property (@(posedge clk) disable iff (rst)
    !result_valid |-> $stable(cond_met));

  // R1: carry test against polarity, immediate path
  a_r1_carry: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !cfg_wait_fresh && cfg_carry_test)
      |=> (cond_met == ($past(alu_carry) == $past(cfg_polarity))));
endmodule

// File: tb/tb_branch_cond_eval.sv
module tb_branch_cond_eval;
  localparam int DW = 8;
  localparam int PW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 0, c_carry = 0, c_pol = 0, c_den = 0, c_pen = 0, c_wait = 0;
  logic [PW-1:0] c_phase = '0, bus_phase = '0;
  logic [DW-1:0] c_mask = '0, c_value = '0, first_byte = '0;
  logic alu_carry = 0, phase_fresh = 0, target_mode = 0, atn_active = 0;
  logic busy, result_valid, cond_met;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  branch_cond_eval #(.DATA_W(DW), .PHASE_W(PW)) dut (
    .clk(clk), .rst(rst), .start(start),
    .cfg_carry_test(c_carry), .cfg_polarity(c_pol), .cfg_data_en(c_den),
    .cfg_phase_en(c_pen), .cfg_wait_fresh(c_wait), .cfg_phase(c_phase),
    .cfg_mask(c_mask), .cfg_value(c_value), .alu_carry(alu_carry),
    .bus_phase(bus_phase), .phase_fresh(phase_fresh), .first_byte(first_byte),
    .target_mode(target_mode), .atn_active(atn_active),
    .busy(busy), .result_valid(result_valid), .cond_met(cond_met));

  typedef struct packed {
    logic carry, pol, den, pen;
    logic [PW-1:0] ph;
    logic [DW-1:0] mask, value;
  } cfg_t;

  typedef struct packed {
    logic carry;
    logic [PW-1:0] ph;
    logic [DW-1:0] byte_in;
    logic tm, atn;
  } st_t;

  function automatic logic expect_met(cfg_t c, st_t s);
    logic dm, pm;
    if (c.carry) return s.carry == c.pol;
    if (!c.den && !c.pen) return 1'b1;
    dm = ((s.byte_in ^ c.value) & ~c.mask) == '0;
    pm = s.tm ? s.atn : (s.ph == c.ph);
    if (c.pol) return (!c.den || dm) && (!c.pen || pm);
    return (!c.den || !dm) && (!c.pen || !pm);
  endfunction

  function automatic string tag_of(cfg_t c);
    if (c.carry) return "R1";
    if (!c.den && !c.pen) return "R2";
    return "R6";
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic put_cfg(cfg_t c);
    c_carry = c.carry; c_pol = c.pol; c_den = c.den; c_pen = c.pen;
    c_phase = c.ph; c_mask = c.mask; c_value = c.value;
  endtask

  task automatic put_st(st_t s);
    alu_carry = s.carry; bus_phase = s.ph; first_byte = s.byte_in;
    target_mode = s.tm; atn_active = s.atn;
  endtask

  function automatic cfg_t rand_cfg();
    cfg_t c;
    c = cfg_t'({$urandom, $urandom});
    c.carry = ($urandom % 4) == 0;
    if ($urandom % 2) c.mask = '0;
    return c;
  endfunction

  function automatic st_t rand_st(cfg_t c);
    st_t s;
    s = st_t'($urandom);
    if ($urandom % 2) s.byte_in = c.value ^ (DW'(1) << ($urandom % DW));
    if ($urandom % 3 == 0) s.byte_in = c.value;
    if ($urandom % 2) s.ph = c.ph;
    return s;
  endfunction

  task automatic scramble();
    put_cfg(cfg_t'({$urandom, $urandom}));
    put_st(st_t'($urandom));
  endtask

  task automatic run_imm(cfg_t c, st_t s, string tag);
    logic e;
    e = expect_met(c, s);
    @(negedge clk);
    put_cfg(c); c_wait = 0; put_st(s); start = 1; phase_fresh = 0;
    @(negedge clk);
    chk("R7", "valid", result_valid, 1'b1);
    chk(tag, "cond_met", cond_met, e);
    start = 0; scramble();
    @(negedge clk);
    chk("R7", "single pulse", result_valid, 1'b0);
    chk("R10", "held", cond_met, e);
  endtask

  task automatic run_wait(cfg_t c, st_t s, int gap, bit early_fresh, bit restart);
    logic e;
    e = expect_met(c, s);
    @(negedge clk);
    put_cfg(c); c_wait = 1; put_st(rand_st(c)); start = 1;
    phase_fresh = early_fresh;
    @(negedge clk);
    chk("R8", "busy after issue", busy, 1'b1);
    chk("R8", "no early result", result_valid, 1'b0);
    start = 0; phase_fresh = 0;
    for (int k = 0; k < gap; k++) begin
      scramble(); c_wait = $urandom % 2;
      start = restart;
      @(negedge clk);
      chk("R9", "still busy", busy, 1'b1);
      chk("R9", "no result while waiting", result_valid, 1'b0);
    end
    start = 0; scramble(); put_st(s); phase_fresh = 1;
    @(negedge clk);
    phase_fresh = 0;
    chk("R8", "valid after fresh phase", result_valid, 1'b1);
    chk("R8", "busy released", busy, 1'b0);
    chk("R8", "captured cfg result", cond_met, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cfg_t c;
    st_t s;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R10", "reset busy", busy, 1'b0);
    chk("R10", "reset valid", result_valid, 1'b0);
    chk("R10", "reset cond_met", cond_met, 1'b0);
    rst = 0;

    // R1: carry mode ignores matching compares
    c = '{carry:1, pol:0, den:1, pen:1, ph:3'd2, mask:'0, value:8'h5A};
    s = '{carry:1, ph:3'd2, byte_in:8'h5A, tm:0, atn:0};
    run_imm(c, s, "R1");
    c.pol = 1; run_imm(c, s, "R1");
    // R2: nothing enabled, polarity 0
    c = '{carry:0, pol:0, den:0, pen:0, ph:3'd1, mask:'0, value:8'h00};
    s = '{carry:0, ph:3'd6, byte_in:8'hFF, tm:0, atn:1};
    run_imm(c, s, "R2");
    // R3: masked bits ignored, one unmasked bit differs
    c = '{carry:0, pol:1, den:1, pen:0, ph:3'd0, mask:8'h7F, value:8'h80};
    s = '{carry:0, ph:3'd0, byte_in:8'hC3, tm:0, atn:0};
    run_imm(c, s, "R3");
    s.byte_in = 8'h43; run_imm(c, s, "R3");
    c.mask = 8'hF0; c.value = 8'h05; s.byte_in = 8'hA4; run_imm(c, s, "R3");
    // R4: initiator phase compare
    c = '{carry:0, pol:1, den:0, pen:1, ph:3'd7, mask:'0, value:'0};
    s = '{carry:0, ph:3'd7, byte_in:'0, tm:0, atn:0};
    run_imm(c, s, "R4");
    s.ph = 3'd3; run_imm(c, s, "R4");
    // R5: target mode tests attention, phase ignored
    s = '{carry:0, ph:3'd7, byte_in:'0, tm:1, atn:0};
    run_imm(c, s, "R5");
    s.atn = 1; s.ph = 3'd0; run_imm(c, s, "R5");
    // R6: both enabled, polarity 0 needs both mismatching
    c = '{carry:0, pol:0, den:1, pen:1, ph:3'd4, mask:'0, value:8'h11};
    s = '{carry:0, ph:3'd4, byte_in:8'h22, tm:0, atn:0};
    run_imm(c, s, "R6");
    s.ph = 3'd5; run_imm(c, s, "R6");
    c.pol = 1; s.ph = 3'd4; run_imm(c, s, "R6");

    // R8/R9: wait path, early fresh phase and restarts
    c = '{carry:0, pol:1, den:1, pen:1, ph:3'd2, mask:8'h0F, value:8'h30};
    s = '{carry:0, ph:3'd2, byte_in:8'h3C, tm:0, atn:0};
    run_wait(c, s, 0, 1'b1, 1'b0);
    run_wait(c, s, 3, 1'b1, 1'b1);
    s.ph = 3'd1; run_wait(c, s, 2, 1'b0, 1'b1);

    for (int i = 0; i < 300; i++) begin
      c = rand_cfg(); s = rand_st(c);
      run_imm(c, s, tag_of(c));
    end
    for (int i = 0; i < 60; i++) begin
      c = rand_cfg(); s = rand_st(c);
      run_wait(c, s, $urandom % 5, $urandom % 2, $urandom % 2);
    end

    // R10: reset in mid-wait clears outputs
    @(negedge clk); put_cfg(c); c_wait = 1; start = 1;
    @(negedge clk); start = 0; rst = 1;
    @(negedge clk); rst = 0;
    chk("R10", "busy cleared", busy, 1'b0);
    chk("R10", "cond_met cleared", cond_met, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule